// File: doc/BRIEF.md
# Byte FIFO Level and Interrupt Hub

This block holds two byte queues between a register front end and a serial engine. One queue carries bytes that the host writes out toward the engine, and the other carries bytes that the engine receives in toward the host. The block reports each queue's fill level together with its full and empty flags. It raises sticky interrupt causes when a queue drops to or rises past a programmable watermark, when an access hits a full or empty queue, when received bytes sit unread for too long, and when the engine reports the end of a transfer.

Each cause lives in a status register that software clears by writing ones. The single interrupt line is the registered OR of the status bits that the enable mask admits. A queue whose enable is low is held empty and ignores all accesses. The bus decoder and the serial engine sit outside the block and connect to its plain ports.

Top module: `fifo_irq_hub`

## Requirements
- R1: After reset both queue levels are 0, both empty flags are 1, both full flags are 0, every status bit is 0, and `irq` is 0. `fifo_stat` therefore reads 0x01000100.
- R2: Each queue holds 64 bytes and returns them in the order they were written. `fifo_stat` carries the outbound level in [6:0], outbound full in bit 7 and outbound empty in bit 8. It carries the inbound level in [22:16], inbound full in bit 23 and inbound empty in bit 24. All other bits are 0. A level changes on the clock edge that accepts the access.
- R3: A pop that is accepted places the oldest byte on `eng_tx_data` (outbound queue) or `host_rx_data` (inbound queue) after the same edge. The byte then stays there until the next accepted pop.
- R4: While a queue's enable is low, its level is forced to 0 on every edge, its pushes and pops are ignored, and its accesses set no error status.
- R5: Status bit 0 is set on an edge when the outbound queue is enabled and its level before that edge is at or below `tx_trig`. Status bit 1 is set on an edge when the inbound queue is enabled and its level before that edge is at or above `rx_trig`.
- R6: A push to a full queue with no accepted pop in the same cycle is dropped, and the level does not change. The push sets status bit 3 (outbound) or bit 5 (inbound) on that edge. A push and a pop in the same cycle on a full queue are both accepted.
- R7: A pop from an empty queue is dropped, and the data output keeps its value. The pop sets status bit 2 (outbound) or bit 4 (inbound) on that edge.
- R8: While the inbound queue is not empty and sees no accepted push or pop, each `eng_tick` advances an idle count. The (`trail_limit`+1)-th such tick sets status bit 6. The bit is set only once until an accepted inbound access occurs or the inbound queue becomes empty.
- R9: A pulse on `eng_xfer_done` sets status bit 9 on that edge.
- R10: When `stat_clr_we` is high, each status bit whose mask bit is 1 is cleared. A cause that occurs on the same edge wins over the clear. Bits 7 and 8 always read 0.
- R11: `irq` is updated on the same edge as the status. It equals the OR of the new status ANDed with `irq_en` as sampled before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Outbound queue enable |
| rx_en | input | 1 | Inbound queue enable |
| tx_trig | input | 7 | Outbound almost-empty watermark |
| rx_trig | input | 7 | Inbound almost-full watermark |
| trail_limit | input | 4 | Idle ticks before the trailing cause |
| host_tx_wr | input | 1 | Host pushes a byte into the outbound queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pops a byte from the inbound queue |
| host_rx_data | output | 8 | Byte popped by the host |
| eng_tx_pop | input | 1 | Engine pops a byte from the outbound queue |
| eng_tx_data | output | 8 | Byte popped by the engine |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| eng_tick | input | 1 | Engine idle time tick |
| eng_xfer_done | input | 1 | Engine end-of-transfer pulse |
| irq_en | input | 10 | Per-cause interrupt enable mask |
| stat_clr_we | input | 1 | Write-one-to-clear strobe |
| stat_clr_mask | input | 10 | Bits to clear |
| irq_stat | output | 10 | Sticky interrupt causes |
| fifo_stat | output | 32 | Levels and full/empty flags |
| irq | output | 1 | Interrupt request |

## Verification
Levels, flags and popped data are due one edge after the access that changes them. Error, trailing, transfer and clear effects reach `irq_stat` and `irq` on that same edge. Watermark causes lag one edge further, because they compare the levels that stood before the edge. The bench drives each cycle's inputs at the falling edge and updates a reference model as the rising edge would. It then compares every output at the next falling edge. A dedicated watermark check pushes a single byte and expects bit 1 to stay clear on the push edge and to appear on the following idle edge.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int STAT_W  = 10;
  localparam int B_TX_AE = 0;
  localparam int B_RX_AF = 1;
  localparam int B_TX_UR = 2;
  localparam int B_TX_OR = 3;
  localparam int B_RX_UR = 4;
  localparam int B_RX_OR = 5;
  localparam int B_TRAIL = 6;
  localparam int B_XFER  = 9;
endpackage

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   push,
  input  logic [DW-1:0]          push_data,
  input  logic                   pop,
  output logic [DW-1:0]          pop_data,
  output logic [$clog2(DEPTH):0] level,
  output logic                   full,
  output logic                   empty,
  output logic                   overrun,
  output logic                   underrun,
  output logic                   moved
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          ok_push, ok_pop;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign ok_pop   = en && pop && !empty;
  assign ok_push  = en && push && (!full || ok_pop);
  assign overrun  = en && push && full && !ok_pop;
  assign underrun = en && pop && empty;
  assign moved    = ok_push || ok_pop;

  // storage without reset so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (ok_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (ok_pop) begin
      pop_data <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (ok_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (ok_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level <= level + LW'(ok_push) - LW'(ok_pop);
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  a_r6_overrun_keeps_level: assert property (@(posedge clk) disable iff (rst)
    overrun |=> level == $past(level));
  a_r7_underrun_holds_data: assert property (@(posedge clk) disable iff (rst)
    underrun |=> $stable(pop_data));
  a_r4_disabled_flushed: assert property (@(posedge clk) disable iff (rst)
    !en |=> level == '0);
endmodule

// File: rtl/fifo_trail_timer.sv
module fifo_trail_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nonempty,
  input  logic          activity,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;
  logic          fired;
  logic          idle;

  assign idle = nonempty && !activity;
  assign fire = idle && tick && (cnt == limit) && !fired;

  always_ff @(posedge clk) begin
    if (rst || !idle) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (tick) begin
      if (fire)            fired <= 1'b1;
      else if (cnt != limit) cnt <= cnt + 1'b1;
    end
  end

  a_r8_single_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] en_mask,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] stat_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign stat_n[i] = (stat[i] && !(clr_we && clr_mask[i])) || set[i];

    always_ff @(posedge clk) begin
      if (rst) stat[i] <= 1'b0;
      else     stat[i] <= stat_n[i];
    end

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[i] && !set[i]) |=> !stat[i]);
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> stat[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_n & en_mask);
  end

  a_r11_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat & $past(en_mask)));
endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub #(
  parameter int DEPTH   = 64,
  parameter int DW      = 8,
  parameter int TRAIL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tx_en,
  input  logic                      rx_en,
  input  logic [$clog2(DEPTH):0]    tx_trig,
  input  logic [$clog2(DEPTH):0]    rx_trig,
  input  logic [TRAIL_W-1:0]        trail_limit,
  input  logic                      host_tx_wr,
  input  logic [DW-1:0]             host_tx_data,
  input  logic                      host_rx_rd,
  output logic [DW-1:0]             host_rx_data,
  input  logic                      eng_tx_pop,
  output logic [DW-1:0]             eng_tx_data,
  input  logic                      eng_rx_push,
  input  logic [DW-1:0]             eng_rx_data,
  input  logic                      eng_tick,
  input  logic                      eng_xfer_done,
  input  logic [fifo_irq_pkg::STAT_W-1:0] irq_en,
  input  logic                      stat_clr_we,
  input  logic [fifo_irq_pkg::STAT_W-1:0] stat_clr_mask,
  output logic [fifo_irq_pkg::STAT_W-1:0] irq_stat,
  output logic [31:0]               fifo_stat,
  output logic                      irq
);
  import fifo_irq_pkg::*;
  localparam int LW = $clog2(DEPTH) + 1;

  logic [LW-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, tx_or, tx_ur, tx_moved;
  logic rx_full, rx_empty, rx_or, rx_ur, rx_moved;
  logic trail_fire;
  logic [STAT_W-1:0] set;

  fifo_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst(rst), .en(tx_en),
    .push(host_tx_wr), .push_data(host_tx_data),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .overrun(tx_or), .underrun(tx_ur), .moved(tx_moved)
  );

  fifo_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst(rst), .en(rx_en),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_rx_rd), .pop_data(host_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .overrun(rx_or), .underrun(rx_ur), .moved(rx_moved)
  );

  fifo_trail_timer #(.CW(TRAIL_W)) u_trail (
    .clk(clk), .rst(rst),
    .nonempty(!rx_empty), .activity(rx_moved || !rx_en),
    .tick(eng_tick), .limit(trail_limit), .fire(trail_fire)
  );

  always_comb begin
    set          = '0;
    set[B_TX_AE] = tx_en && (tx_level <= tx_trig);
    set[B_RX_AF] = rx_en && (rx_level >= rx_trig);
    set[B_TX_UR] = tx_ur;
    set[B_TX_OR] = tx_or;
    set[B_RX_UR] = rx_ur;
    set[B_RX_OR] = rx_or;
    set[B_TRAIL] = trail_fire;
    set[B_XFER]  = eng_xfer_done;
  end

  fifo_irq_status #(.W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set(set),
    .clr_we(stat_clr_we), .clr_mask(stat_clr_mask),
    .en_mask(irq_en), .stat(irq_stat), .irq(irq)
  );

  always_comb begin
    fifo_stat              = '0;
    fifo_stat[LW-1:0]      = tx_level;
    fifo_stat[7]           = tx_full;
    fifo_stat[8]           = tx_empty;
    fifo_stat[16+LW-1:16]  = rx_level;
    fifo_stat[23]          = rx_full;
    fifo_stat[24]          = rx_empty;
  end

  a_r9_xfer_sets: assert property (@(posedge clk) disable iff (rst)
    eng_xfer_done |=> irq_stat[B_XFER]);
  a_r5_tx_watermark: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_level <= tx_trig) |=> irq_stat[B_TX_AE]);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

// File: tb/fifo_irq_hub_bench.sv
module fifo_irq_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_en = 1'b0;
  logic [6:0] tx_trig = '0, rx_trig = '0;
  logic [3:0] trail_limit = '0;
  logic host_tx_wr = 1'b0, host_rx_rd = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0] host_tx_data = '0, eng_rx_data = '0;
  logic eng_tick = 1'b0, eng_xfer_done = 1'b0, stat_clr_we = 1'b0;
  logic [9:0] irq_en = '0, stat_clr_mask = '0;
  logic [7:0] host_rx_data, eng_tx_data;
  logic [9:0] irq_stat;
  logic [31:0] fifo_stat;
  logic irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] txq[$], rxq[$];
  logic [9:0] m_stat = '0;
  logic m_irq = 1'b0;
  logic [7:0] m_txd = '0, m_rxd = '0;
  int t_cnt = 0;
  bit t_fired = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_irq_hub u_fifo_irq_hub (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .trail_limit(trail_limit),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_tick(eng_tick), .eng_xfer_done(eng_xfer_done),
    .irq_en(irq_en), .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
    .irq_stat(irq_stat), .fifo_stat(fifo_stat), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fifo_stat(int tl, int rl);
    logic [31:0] e = '0;
    e[6:0]   = 7'(tl);
    e[7]     = (tl == DEPTH);
    e[8]     = (tl == 0);
    e[22:16] = 7'(rl);
    e[23]    = (rl == DEPTH);
    e[24]    = (rl == 0);
    return e;
  endfunction

  // reference model: advance by one rising edge using the inputs now driven
  function automatic void model_edge();
    int tl = txq.size();
    int rl = rxq.size();
    logic [9:0] set = '0;
    bit t_okpop, t_okpush, r_okpop, r_okpush, fire;
    t_okpop  = tx_en && eng_tx_pop && tl > 0;
    t_okpush = tx_en && host_tx_wr && (tl < DEPTH || t_okpop);
    r_okpop  = rx_en && host_rx_rd && rl > 0;
    r_okpush = rx_en && eng_rx_push && (rl < DEPTH || r_okpop);
    set[0] = tx_en && (tl <= int'(tx_trig));
    set[1] = rx_en && (rl >= int'(rx_trig));
    set[2] = tx_en && eng_tx_pop && tl == 0;
    set[3] = tx_en && host_tx_wr && tl == DEPTH && !t_okpop;
    set[4] = rx_en && host_rx_rd && rl == 0;
    set[5] = rx_en && eng_rx_push && rl == DEPTH && !r_okpop;
    fire = 0;
    if (r_okpush || r_okpop || rl == 0 || !rx_en) begin
      t_cnt = 0; t_fired = 0;
    end else if (eng_tick) begin
      if (t_cnt == int'(trail_limit) && !t_fired) begin fire = 1; t_fired = 1; end
      else if (t_cnt != int'(trail_limit)) t_cnt++;
    end
    set[6] = fire;
    set[9] = eng_xfer_done;
    m_stat = (stat_clr_we ? (m_stat & ~stat_clr_mask) : m_stat) | set;
    m_irq  = |(m_stat & irq_en);
    if (!tx_en) txq.delete();
    else begin
      if (t_okpop) m_txd = txq.pop_front();
      if (t_okpush) txq.push_back(host_tx_data);
    end
    if (!rx_en) rxq.delete();
    else begin
      if (r_okpop) m_rxd = rxq.pop_front();
      if (r_okpush) rxq.push_back(eng_rx_data);
    end
  endfunction

  task automatic step(string req, logic twr, logic [7:0] td, logic rrd, logic tpop,
                      logic rpush, logic [7:0] rd, logic tick, logic xfer,
                      logic clrwe, logic [9:0] clrm);
    host_tx_wr = twr; host_tx_data = td; host_rx_rd = rrd; eng_tx_pop = tpop;
    eng_rx_push = rpush; eng_rx_data = rd; eng_tick = tick; eng_xfer_done = xfer;
    stat_clr_we = clrwe; stat_clr_mask = clrm;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("R2", "fifo_stat", fifo_stat, exp_fifo_stat(txq.size(), rxq.size()));
    chk(req, "irq_stat", {22'd0, irq_stat}, {22'd0, m_stat});
    chk("R11", "irq", {31'd0, irq}, {31'd0, m_irq});
    chk("R3", "eng_tx_data", {24'd0, eng_tx_data}, {24'd0, m_txd});
    chk("R3", "host_rx_data", {24'd0, host_rx_data}, {24'd0, m_rxd});
  endtask

  task automatic idle(string req);
    step(req, 0, 8'h00, 0, 0, 0, 8'h00, 0, 0, 0, 10'h000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "reset fifo_stat", fifo_stat, 32'h0100_0100);
    chk("R1", "reset irq_stat", {22'd0, irq_stat}, 32'd0);
    chk("R1", "reset irq", {31'd0, irq}, 32'd0);

    tx_en = 1; rx_en = 1; tx_trig = 7'd16; rx_trig = 7'd48;
    trail_limit = 4'hF; irq_en = 10'h3FF;

    // R5: one inbound byte with watermark 1, bit 1 lags one edge
    rx_trig = 7'd1;
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 10'h3FF);
    step("R5", 0, 0, 0, 0, 1, 8'h5A, 0, 0, 1, 10'h3FF);
    chk("R5", "af not yet", {31'd0, irq_stat[1]}, 32'd0);
    idle("R5");
    chk("R5", "af one edge later", {31'd0, irq_stat[1]}, 32'd1);
    step("R3", 0, 0, 1, 0, 0, 0, 0, 0, 1, 10'h3FF);
    chk("R3", "first inbound byte", {24'd0, host_rx_data}, 32'h5A);
    rx_trig = 7'd48;

    // R6 outbound fill with overrun on the 65th write
    for (int i = 0; i < DEPTH + 1; i++) step("R6", 1, 8'(i + 3), 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "tx overrun bit", {31'd0, irq_stat[3]}, 32'd1);
    chk("R2", "tx full", {31'd0, fifo_stat[7]}, 32'd1);
    // full: push with pop both accepted
    step("R6", 1, 8'hEE, 0, 1, 0, 0, 0, 0, 1, 10'h3FF);
    chk("R6", "no overrun with pop", {31'd0, irq_stat[3]}, 32'd0);
    // R7 drain and underrun
    for (int i = 0; i < DEPTH + 1; i++) step("R7", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7", "tx underrun bit", {31'd0, irq_stat[2]}, 32'd1);

    // inbound fill, overrun, drain, underrun
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 10'h3FF);
    for (int i = 0; i < DEPTH + 1; i++) step("R6", 0, 0, 0, 0, 1, 8'(200 - i), 0, 0, 0, 0);
    chk("R6", "rx overrun bit", {31'd0, irq_stat[5]}, 32'd1);
    for (int i = 0; i < DEPTH + 1; i++) step("R7", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "rx underrun bit", {31'd0, irq_stat[4]}, 32'd1);

    // R8 trailing
    step("R10", 0, 0, 0, 0, 1, 8'h11, 0, 0, 1, 10'h3FF);
    step("R8", 0, 0, 0, 0, 1, 8'h22, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "not yet fired", {31'd0, irq_stat[6]}, 32'd0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "fired", {31'd0, irq_stat[6]}, 32'd1);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 10'h040);
    for (int i = 0; i < 20; i++) step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "fires once", {31'd0, irq_stat[6]}, 32'd0);
    trail_limit = 4'd2;
    step("R8", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "refire after pop", {31'd0, irq_stat[6]}, 32'd1);

    // R9 and R10
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1, 10'h3FF);
    chk("R9", "xfer wins over clear", {31'd0, irq_stat[9]}, 32'd1);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 10'h200);
    chk("R10", "xfer cleared", {31'd0, irq_stat[9]}, 32'd0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 10'h3FF);
    chk("R10", "unused bits zero", {30'd0, irq_stat[8:7]}, 32'd0);

    // R4 disabled outbound queue
    tx_en = 0;
    step("R4", 1, 8'h99, 0, 1, 0, 0, 0, 0, 1, 10'h3FF);
    chk("R4", "tx level stays 0", {25'd0, fifo_stat[6:0]}, 32'd0);
    chk("R4", "no tx errors", {30'd0, irq_stat[3:2]}, 32'd0);
    tx_en = 1;

    // R11 masking
    irq_en = 10'h000;
    step("R11", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R11", "masked irq low", {31'd0, irq}, 32'd0);
    irq_en = 10'h200;
    idle("R11");
    chk("R11", "unmasked irq high", {31'd0, irq}, 32'd1);

    // R5 constrained random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 99) == 0) begin
        tx_en = ($urandom_range(0, 9) != 0); rx_en = ($urandom_range(0, 9) != 0);
        tx_trig = 7'($urandom_range(0, 64)); rx_trig = 7'($urandom_range(0, 64));
        trail_limit = 4'($urandom_range(0, 15)); irq_en = 10'($urandom);
      end
      step("R5", 1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), 8'($urandom),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 30) == 0),
           1'($urandom_range(0, 7) == 0), 10'($urandom));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule